// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit linear address into a physical page frame. It reads up to four levels of 8-byte translation entries from memory: the root table, then the directory-pointer table, then the directory, then the page table. A walk can stop early on a 1 GB page (large bit in the directory-pointer entry) or on a 2 MB page (large bit in the directory entry). As it descends, the walker checks each entry for presence and reserved bits. At the leaf it evaluates user/supervisor and write privilege. It then writes the accessed and dirty flags back to memory, starting at the root and ending at the leaf.

A requester places a translation request while `req_ready` is high. The request carries the address, an access type, a user-mode flag, the write-protect and global-page controls, and the root table base. The walker has one memory port and never has more than one transaction open on it. A request is held until it is acknowledged. Each walk ends with a one-cycle `done` pulse that carries either a translation or a fault code.

Top module: `ptw_walker`

## Requirements
- R1: The root entry address is root base bits 51:12 joined with linear bits 47:39 at address bits 11:3. Each lower entry address is the parent entry bits 51:12 joined with a 9-bit index at bits 11:3. The index is linear 38:30 for the directory-pointer level, 29:21 for the directory level and 20:12 for the page-table level.
- R2: Entries are read root first, one level after another. `mem_req` stays high, with `mem_addr` and `mem_we` stable, until `mem_ack`, and only one transaction is open at a time.
- R3: A 4 KB leaf gives a frame equal to entry bits 51:12 and `off_mask` 0xFFF.
- R4: Bit 7 set in a directory entry ends the walk on a 2 MB page. The frame is entry 51:21 joined with linear 20:12, and `off_mask` is 0x1FFFFF.
- R5: Bit 7 set in a directory-pointer entry ends the walk on a 1 GB page. The frame is entry 51:30 joined with linear 29:12, and `off_mask` is 0x3FFFFFFF.
- R6: `acc_bits[1:0]` is the AND of entry bits 2:1 over every visited level, with bit 1 the user flag and bit 0 the writable flag. `acc_bits[2]` is leaf bit 8 (global) when `cfg_pge` is 1. It is 0 when `cfg_pge` is 0, whatever bit 8 holds.
- R7: A write is an access type with bit 0 set, so 01 is a write and 11 is a read-modify-write. A user access needs the combined user flag, and a user write also needs the combined writable flag. A supervisor write to a non-writable page faults only when `cfg_wp` is 1.
- R8: An entry with bit 0 clear ends the walk with a not-present fault, `fault_code[0]`=0.
- R9: A reserved-bit fault sets `fault_code[3]` and `fault_code[0]`. It is raised by any of the following:
  - any set bit in 62:52 at any level;
  - bit 7 in the root entry;
  - any set bit in 29:13 of a 1 GB leaf;
  - any set bit in 20:13 of a 2 MB leaf.
- R10: On an instruction fetch (access type 10), bit 63 set at any visited level raises a protection fault with `fault_code[4]` and `fault_code[0]` set.
- R11: After a successful check, each non-leaf level from the root down writes its entry back with bit 5 set, and only if bit 5 was clear. All of these writes come before the leaf write.
- R12: The leaf is written back with bit 5 set, and with bit 6 set too on a write, only when bit 5 is clear or when a write finds bit 6 clear.
- R13: A faulting walk makes no memory writes. It reports `fault`=1 with `fault_code` = {fetch, reserved, user, write, present/protection}, and `frame`, `off_mask` and `acc_bits` all zero.
- R14: After reset `req_ready` is 1 and `done` and `mem_req` are 0. `done` is a single-cycle pulse per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken while req_ready) |
| req_ready | output | 1 | Walker idle |
| req_laddr | input | 48 | Linear address |
| req_acc | input | 2 | Access type: 00 read, 01 write, 10 fetch, 11 read-modify-write |
| req_user | input | 1 | User-mode access |
| cfg_wp | input | 1 | Write-protect enforcement for supervisor |
| cfg_pge | input | 1 | Global-page reporting enable |
| cfg_root | input | 52 | Root table base (bits 51:12 used) |
| mem_req | output | 1 | Memory transaction pending |
| mem_we | output | 1 | Transaction is a write |
| mem_addr | output | 52 | Entry byte address |
| mem_wdata | output | 64 | Entry write data |
| mem_ack | input | 1 | Transaction complete |
| mem_rdata | input | 64 | Entry read data, valid with mem_ack |
| done | output | 1 | Walk finished pulse |
| fault | output | 1 | Walk ended in a fault |
| fault_code | output | 5 | {fetch, reserved, user, write, protection} |
| frame | output | 40 | Physical address bits 51:12 |
| off_mask | output | 30 | Page offset mask |
| acc_bits | output | 3 | {global, user, writable} |

## Verification
The assertions assume that `mem_ack` arrives only while `mem_req` is high, is a one-cycle pulse, and comes with valid read data. They also assume that `req_valid` is raised only while the walker is idle. The bench memory answers only after it sees a request, after a chosen delay of zero to two cycles. It drops `mem_ack` in the next cycle. Requests are issued one at a time, each after the previous `done`, so the stimulus never breaks these assumptions. The bench compares every memory transaction and every result against a behavioural walk over a sparse memory image. That image includes the flags the walker wrote back earlier.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  // positions of the entry flags the walker interprets
  localparam int EB_PRESENT = 0;
  localparam int EB_ACCESSED = 5;
  localparam int EB_DIRTY = 6;
  localparam int EB_LARGE = 7;
  localparam int EB_GLOBAL = 8;
  localparam int EB_NOEXEC = 63;
  localparam int ENT_W = 64;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_READ,
    WS_CHECK,
    WS_WB,
    WS_WRITE
  } walk_state_e;
endpackage

// File: rtl/ptw_entry_chk.sv
module ptw_entry_chk
  import ptw_pkg::*;
#(
  parameter int PA_W = 52,
  parameter int IDX_W = 9,
  parameter int LEVELS = 4,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic [ENT_W-1:0] ent,
  input  logic [LVL_W-1:0] lvl,
  output logic             present,
  output logic             leaf,
  output logic             rsvd,
  output logic             noexec
);
  logic big, large_low;
  logic unused_bits;

  assign unused_bits = ^{ent[12:8], ent[6:1]};
  assign present = ent[EB_PRESENT];
  assign noexec = ent[EB_NOEXEC];
  // large-page termination is legal only on the middle levels
  assign big = ent[EB_LARGE] && (lvl != '0) && (int'(lvl) != LEVELS - 1);
  assign leaf = (lvl == '0) || big;

  // low frame bits of a large leaf must be zero (R9)
  always_comb begin
    large_low = 1'b0;
    for (int b = 13; b < PA_W; b++) begin
      if (b < 12 + IDX_W * int'(lvl)) large_low = large_low | ent[b];
    end
  end

  assign rsvd = (|ent[62:PA_W]) ||
                ((int'(lvl) == LEVELS - 1) && ent[EB_LARGE]) ||
                (big && large_low);
endmodule

// File: rtl/ptw_perm_chk.sv
module ptw_perm_chk (
  input  logic       wp,
  input  logic       user,
  input  logic       wr,
  input  logic [1:0] comb,
  output logic       allow
);
  // comb[1] = user flag, comb[0] = writable flag (R7)
  always_comb begin
    if (user) allow = comb[1] && (!wr || comb[0]);
    else      allow = !wr || comb[0] || !wp;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int PA_W = 52,
  parameter int IDX_W = 9,
  parameter int LEVELS = 4,
  localparam int LA_W = 12 + IDX_W * LEVELS,
  localparam int FRAME_W = PA_W - 12,
  localparam int OFF_W = 12 + IDX_W * (LEVELS - 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LA_W-1:0]    req_laddr,
  input  logic [1:0]         req_acc,
  input  logic               req_user,
  input  logic               cfg_wp,
  input  logic               cfg_pge,
  input  logic [PA_W-1:0]    cfg_root,
  output logic               mem_req,
  output logic               mem_we,
  output logic [PA_W-1:0]    mem_addr,
  output logic [ENT_W-1:0]   mem_wdata,
  input  logic               mem_ack,
  input  logic [ENT_W-1:0]   mem_rdata,
  output logic               done,
  output logic               fault,
  output logic [4:0]         fault_code,
  output logic [FRAME_W-1:0] frame,
  output logic [OFF_W-1:0]   off_mask,
  output logic [2:0]         acc_bits
);
  localparam int LVL_W = $clog2(LEVELS);
  localparam int VPN_W = LA_W - 12;
  localparam logic [LVL_W-1:0] TOP = LVL_W'(LEVELS - 1);

  walk_state_e state;
  logic [LVL_W-1:0] lvl_q, leaf_q, wlvl_q;
  logic [VPN_W-1:0] vpn_q;
  logic wr_q, fetch_q, user_q, wp_q, pge_q, nx_q;
  logic [1:0] comb_q;
  logic [ENT_W-1:0] ent_q [LEVELS];
  logic [PA_W-1:0] eaddr_q [LEVELS];
  logic mem_we_q;
  logic [PA_W-1:0] mem_addr_q;
  logic [ENT_W-1:0] mem_wdata_q;
  logic done_q, fault_q;
  logic [4:0] code_q;
  logic [FRAME_W-1:0] frame_q;
  logic [OFF_W-1:0] mask_q;
  logic [2:0] accb_q;
  logic unused_in;

  assign unused_in = ^{req_laddr[11:0], cfg_root[11:0]};

  // entry under inspection
  logic c_present, c_leaf, c_rsvd, c_nx, allow, nx_n;
  logic [1:0] comb_n;
  logic [ENT_W-1:0] cur_ent;
  assign cur_ent = ent_q[lvl_q];
  assign comb_n = comb_q & cur_ent[2:1];
  assign nx_n = nx_q | (c_nx & fetch_q);

  ptw_entry_chk #(.PA_W(PA_W), .IDX_W(IDX_W), .LEVELS(LEVELS)) u_chk (
    .ent(cur_ent), .lvl(lvl_q), .present(c_present), .leaf(c_leaf),
    .rsvd(c_rsvd), .noexec(c_nx)
  );

  ptw_perm_chk u_perm (
    .wp(wp_q), .user(user_q), .wr(wr_q), .comb(comb_n), .allow(allow)
  );

  logic chk_fault;
  logic [4:0] chk_code;
  always_comb begin
    chk_fault = 1'b1;
    chk_code = {fetch_q, 1'b0, user_q, wr_q, 1'b0};
    if (!c_present)      chk_code = {fetch_q, 1'b0, user_q, wr_q, 1'b0};
    else if (c_rsvd)     chk_code = {fetch_q, 1'b1, user_q, wr_q, 1'b1};
    else if (c_leaf && (!allow || nx_n))
                         chk_code = {fetch_q, 1'b0, user_q, wr_q, 1'b1};
    else                 chk_fault = 1'b0;
  end

  // flag write-back for the level being swept
  logic [ENT_W-1:0] ent_w, wb_data;
  logic wb_need, wb_last;
  assign ent_w = ent_q[wlvl_q];
  assign wb_last = (wlvl_q == leaf_q);
  always_comb begin
    wb_data = ent_w;
    wb_data[EB_ACCESSED] = 1'b1;
    if (wb_last) begin
      wb_data[EB_DIRTY] = ent_w[EB_DIRTY] | wr_q;
      wb_need = !ent_w[EB_ACCESSED] || (wr_q && !ent_w[EB_DIRTY]);
    end else begin
      wb_need = !ent_w[EB_ACCESSED];
    end
  end

  // result assembly from the leaf entry
  logic [FRAME_W-1:0] frame_n, vpn_ext;
  logic [OFF_W-1:0] mask_n;
  assign vpn_ext = FRAME_W'(vpn_q);
  always_comb begin
    for (int k = 0; k < FRAME_W; k++)
      frame_n[k] = (k < IDX_W * int'(leaf_q)) ? vpn_ext[k] : ent_q[leaf_q][12 + k];
    for (int b = 0; b < OFF_W; b++)
      mask_n[b] = (b < 12 + IDX_W * int'(leaf_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= WS_IDLE;
      lvl_q <= '0; leaf_q <= '0; wlvl_q <= '0;
      vpn_q <= '0; comb_q <= '0; nx_q <= 1'b0;
      wr_q <= 1'b0; fetch_q <= 1'b0; user_q <= 1'b0; wp_q <= 1'b0; pge_q <= 1'b0;
      for (int i = 0; i < LEVELS; i++) begin
        ent_q[i] <= '0;
        eaddr_q[i] <= '0;
      end
      mem_we_q <= 1'b0; mem_addr_q <= '0; mem_wdata_q <= '0;
      done_q <= 1'b0; fault_q <= 1'b0; code_q <= '0;
      frame_q <= '0; mask_q <= '0; accb_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        WS_IDLE: if (req_valid) begin
          vpn_q <= req_laddr[LA_W-1:12];
          wr_q <= req_acc[0];
          fetch_q <= (req_acc == 2'b10);
          user_q <= req_user; wp_q <= cfg_wp; pge_q <= cfg_pge;
          comb_q <= 2'b11; nx_q <= 1'b0;
          lvl_q <= TOP;
          mem_we_q <= 1'b0;
          mem_addr_q <= {cfg_root[PA_W-1:12], req_laddr[LA_W-1 -: IDX_W], 3'b000};
          state <= WS_READ;
        end
        WS_READ: if (mem_ack) begin
          ent_q[lvl_q] <= mem_rdata;
          eaddr_q[lvl_q] <= mem_addr_q;
          state <= WS_CHECK;
        end
        WS_CHECK: begin
          comb_q <= comb_n;
          nx_q <= nx_n;
          if (chk_fault) begin
            done_q <= 1'b1; fault_q <= 1'b1; code_q <= chk_code;
            frame_q <= '0; mask_q <= '0; accb_q <= '0;
            state <= WS_IDLE;
          end else if (c_leaf) begin
            leaf_q <= lvl_q;
            wlvl_q <= TOP;
            state <= WS_WB;
          end else begin
            lvl_q <= lvl_q - LVL_W'(1);
            mem_addr_q <= {cur_ent[PA_W-1:12],
                           vpn_q[IDX_W * (int'(lvl_q) - 1) +: IDX_W], 3'b000};
            state <= WS_READ;
          end
        end
        WS_WB: begin
          if (wb_need) begin
            mem_we_q <= 1'b1;
            mem_addr_q <= eaddr_q[wlvl_q];
            mem_wdata_q <= wb_data;
            state <= WS_WRITE;
          end else if (wb_last) begin
            done_q <= 1'b1; fault_q <= 1'b0; code_q <= '0;
            frame_q <= frame_n; mask_q <= mask_n;
            accb_q <= {pge_q & ent_q[leaf_q][EB_GLOBAL], comb_q};
            state <= WS_IDLE;
          end else begin
            wlvl_q <= wlvl_q - LVL_W'(1);
          end
        end
        WS_WRITE: if (mem_ack) begin
          mem_we_q <= 1'b0;
          if (wb_last) begin
            done_q <= 1'b1; fault_q <= 1'b0; code_q <= '0;
            frame_q <= frame_n; mask_q <= mask_n;
            accb_q <= {pge_q & ent_q[leaf_q][EB_GLOBAL], comb_q};
            state <= WS_IDLE;
          end else begin
            wlvl_q <= wlvl_q - LVL_W'(1);
            state <= WS_WB;
          end
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

  assign req_ready = (state == WS_IDLE);
  assign mem_req = (state == WS_READ) || (state == WS_WRITE);
  assign mem_we = mem_we_q;
  assign mem_addr = mem_addr_q;
  assign mem_wdata = mem_wdata_q;
  assign done = done_q;
  assign fault = fault_q;
  assign fault_code = code_q;
  assign frame = frame_q;
  assign off_mask = mask_q;
  assign acc_bits = accb_q;

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R14
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  np_code_chk: assert property (@(posedge clk) disable iff (rst)
    (done && fault && !fault_code[0]) |-> !fault_code[3]);
  // R11
  wb_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[EB_ACCESSED]);
  // R13
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (frame == '0 && off_mask == '0 && acc_bits == '0));
  // R3
  mask_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !fault) |-> (off_mask[11:0] == 12'hFFF));
endmodule

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic req_valid = 1'b0, req_ready, req_user = 1'b0, cfg_wp = 1'b0, cfg_pge = 1'b0;
  logic [47:0] req_laddr = '0;
  logic [1:0] req_acc = '0;
  logic [51:0] cfg_root = 52'h1000;
  logic mem_req, mem_we, mem_ack, done, fault;
  logic [51:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic [4:0] fault_code;
  logic [39:0] frame;
  logic [29:0] off_mask;
  logic [2:0] acc_bits;

  ptw_walker u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_laddr(req_laddr), .req_acc(req_acc), .req_user(req_user),
    .cfg_wp(cfg_wp), .cfg_pge(cfg_pge), .cfg_root(cfg_root),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .fault(fault),
    .fault_code(fault_code), .frame(frame), .off_mask(off_mask), .acc_bits(acc_bits)
  );

  localparam logic [63:0] F_P = 64'h1, F_RW = 64'h2, F_US = 64'h4, F_PS = 64'h80;
  localparam logic [63:0] F_G = 64'h100, F_NX = 64'h8000_0000_0000_0000;
  localparam logic [63:0] F_ALL = 64'h7;

  int n_cmp = 0, n_bad = 0, lat = 0, wcnt = 0;
  string cur_tag = "";
  logic [63:0] pmem [logic [51:0]];
  logic exp_we [$];
  logic [51:0] exp_addr [$];
  logic [63:0] exp_data [$];
  logic e_fault;
  logic [4:0] e_code;
  logic [39:0] e_frame;
  logic [29:0] e_mask;
  logic [2:0] e_acc;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rdm(input logic [51:0] a);
    return pmem.exists(a) ? pmem[a] : 64'h0;
  endfunction

  function automatic logic [47:0] mkla(input int i3, i2, i1, i0, input int off);
    return {i3[8:0], i2[8:0], i1[8:0], i0[8:0], off[11:0]};
  endfunction

  // build a translation path with tables at fixed pages
  task automatic map(input logic [47:0] la, input int leaf, input logic [63:0] f3, f2, f1, f0,
                     input logic [63:0] pa);
    pmem[{cfg_root[51:12], la[47:39], 3'b0}] = 64'h2000 | f3;
    if (leaf == 2) begin
      pmem[{40'h2, la[38:30], 3'b0}] = pa | f2 | F_PS;
    end else begin
      pmem[{40'h2, la[38:30], 3'b0}] = 64'h3000 | f2;
      if (leaf == 1) pmem[{40'h3, la[29:21], 3'b0}] = pa | f1 | F_PS;
      else begin
        pmem[{40'h3, la[29:21], 3'b0}] = 64'h4000 | f1;
        pmem[{40'h4, la[20:12], 3'b0}] = pa | f0;
      end
    end
  endtask

  function automatic bit rsv(input logic [63:0] e, input int lv);
    return (|e[62:52]) || (lv == 3 && e[7]) || (lv == 2 && e[7] && |e[29:13]) ||
           (lv == 1 && e[7] && |e[20:13]);
  endfunction

  // behavioural model of one walk
  task automatic ref_walk(input logic [47:0] la, input logic [1:0] acc, input logic user, wp, pge);
    logic [63:0] e [4];
    logic [51:0] a [4];
    logic [51:0] addr;
    logic [1:0] comb;
    logic [63:0] msk, phys;
    bit nx, wr, fe, flt, ok;
    int leaf;
    wr = acc[0]; fe = (acc == 2'b10); comb = 2'b11; nx = 0; flt = 0; leaf = 0;
    e_code = 0;
    addr = {cfg_root[51:12], la[47:39], 3'b0};
    for (int lv = 3; lv >= 0; lv--) begin
      e[lv] = rdm(addr); a[lv] = addr;
      exp_we.push_back(1'b0); exp_addr.push_back(addr); exp_data.push_back(64'h0);
      if (!e[lv][0]) begin flt = 1; e_code = {fe, 1'b0, user, wr, 1'b0}; break; end
      if (rsv(e[lv], lv)) begin flt = 1; e_code = {fe, 1'b1, user, wr, 1'b1}; break; end
      if (e[lv][63] && fe) nx = 1;
      comb = comb & e[lv][2:1];
      if (lv == 0 || (lv < 3 && e[lv][7])) begin leaf = lv; break; end
      addr = {e[lv][51:12], la[12 + 9 * (lv - 1) +: 9], 3'b0};
    end
    if (!flt) begin
      ok = user ? (comb[1] && (!wr || comb[0])) : (!wr || comb[0] || !wp);
      if (!ok || nx) begin flt = 1; e_code = {fe, 1'b0, user, wr, 1'b1}; end
    end
    e_fault = flt; e_frame = 0; e_mask = 0; e_acc = 0;
    if (!flt) begin
      for (int lv = 3; lv > leaf; lv--)
        if (!e[lv][5]) begin
          exp_we.push_back(1'b1); exp_addr.push_back(a[lv]); exp_data.push_back(e[lv] | 64'h20);
        end
      if (!e[leaf][5] || (wr && !e[leaf][6])) begin
        exp_we.push_back(1'b1); exp_addr.push_back(a[leaf]);
        exp_data.push_back(e[leaf] | 64'h20 | (wr ? 64'h40 : 64'h0));
      end
      msk = (64'h1 << (12 + 9 * leaf)) - 1;
      phys = ({12'h0, e[leaf][51:0]} & ~msk) | ({16'h0, la} & msk);
      e_frame = phys[51:12]; e_mask = msk[29:0];
      e_acc = {pge & e[leaf][8], comb};
    end
  endtask

  // memory model: answers after lat cycles, one-cycle acknowledge
  initial begin
    mem_ack = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (!rst && mem_req) begin
        if (wcnt >= lat) begin
          wcnt = 0;
          mem_ack = 1'b1;
          if (exp_we.size() == 0) chk(cur_tag, "unexpected transaction", 1, 0);
          else begin
            chk(cur_tag, "txn we", mem_we, exp_we.pop_front());
            chk(cur_tag, "txn addr", mem_addr, exp_addr.pop_front());
            if (mem_we) chk(cur_tag, "txn wdata", mem_wdata, exp_data.pop_front());
            else void'(exp_data.pop_front());
          end
          if (mem_we) pmem[mem_addr] = mem_wdata;
          else mem_rdata = rdm(mem_addr);
        end else wcnt++;
      end
    end
  end

  task automatic run_walk(input string tag, input logic [47:0] la, input logic [1:0] acc,
                          input logic user, wp, pge, input int l);
    int cyc;
    lat = l;
    cur_tag = tag;
    ref_walk(la, acc, user, wp, pge);
    @(negedge clk);
    req_laddr = la; req_acc = acc; req_user = user; cfg_wp = wp; cfg_pge = pge;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    if (!done) chk(tag, "walk timeout", 0, 1);
    else begin
      chk(tag, "fault", fault, e_fault);
      chk(tag, "fault_code", fault_code, e_code);
      chk(tag, "frame", frame, e_frame);
      chk(tag, "off_mask", off_mask, e_mask);
      chk(tag, "acc_bits", acc_bits, e_acc);
      chk(tag, "missing transactions", exp_we.size(), 0);
      @(negedge clk);
      chk("R14", "done pulse width", done, 0);
      chk("R14", "ready after walk", req_ready, 1);
    end
    exp_we.delete(); exp_addr.delete(); exp_data.delete();
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] la1, la2, la3, la4, la5, la6, la7, la8, la9, la10;
    la1 = mkla(1, 1, 3, 5, 'h123);   la2 = mkla(2, 2, 7, 9, 'h456);
    la3 = mkla(3, 3, 5, 17, 'h789);  la4 = mkla(4, 4, 1, 2, 0);
    la5 = mkla(5, 5, 2, 3, 'h10);    la6 = mkla(6, 6, 3, 4, 'h20);
    la7 = mkla(7, 7, 4, 5, 'h30);    la8 = mkla(8, 8, 5, 6, 'h40);
    la9 = mkla(9, 9, 6, 7, 'h50);    la10 = mkla(10, 10, 7, 8, 'h60);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R14", "reset ready", req_ready, 1);
    chk("R14", "reset done", done, 0);
    chk("R14", "reset mem_req", mem_req, 0);

    map(la1, 0, F_ALL, F_ALL, F_ALL, F_ALL, 64'h000F_EDCB_A987_6000);
    run_walk("R1 R2 R3 R11 R12", la1, 2'b00, 1, 0, 0, 0);
    run_walk("R11 R12 accessed already set", la1, 2'b00, 1, 0, 0, 1);
    run_walk("R12 rmw sets dirty", la1, 2'b11, 1, 0, 0, 2);
    run_walk("R12 dirty already set", la1, 2'b01, 1, 0, 0, 0);
    map(la2, 1, F_ALL, F_ALL, 64'h3, 0, 64'h0000_0123_4560_0000);
    run_walk("R4 R11 2M write", la2, 2'b01, 0, 1, 0, 1);
    map(la3, 2, F_ALL, F_ALL | F_G, 0, 0, 64'h0000_00AB_C000_0000);
    run_walk("R5 R6 1G global", la3, 2'b00, 1, 0, 1, 2);
    run_walk("R6 global ignored", la3, 2'b00, 1, 0, 0, 0);
    map(la4, 0, F_ALL, F_ALL, 64'h0, F_ALL, 64'h0000_0000_0055_5000);
    run_walk("R8 R13 not present", la4, 2'b01, 0, 0, 0, 1);
    map(la3, 2, F_ALL, F_ALL | (64'h1 << 20), 0, 0, 64'h0000_00AB_C000_0000);
    run_walk("R9 1G reserved", la3, 2'b00, 0, 0, 0, 0);
    map(la5, 0, F_ALL, F_ALL, F_ALL, F_P | F_RW, 64'h0000_0000_0066_6000);
    run_walk("R7 user to supervisor", la5, 2'b00, 1, 0, 0, 0);
    map(la6, 0, F_ALL, F_ALL, F_P | F_US, F_ALL, 64'h0000_0000_0077_7000);
    run_walk("R7 supervisor write wp off", la6, 2'b01, 0, 0, 0, 1);
    run_walk("R7 supervisor write wp on", la6, 2'b01, 0, 1, 0, 0);
    map(la7, 0, F_ALL, F_ALL, F_ALL, F_ALL | F_NX, 64'h0000_0000_0088_8000);
    run_walk("R10 fetch no-execute", la7, 2'b10, 0, 0, 0, 2);
    run_walk("R10 read no-execute", la7, 2'b00, 0, 0, 0, 0);
    map(la8, 0, F_ALL | F_PS, F_ALL, F_ALL, F_ALL, 64'h0000_0000_0099_9000);
    run_walk("R9 root large bit", la8, 2'b00, 0, 0, 0, 1);
    map(la9, 0, F_ALL, F_ALL, F_ALL, F_ALL | (64'h1 << 55), 64'h0000_0000_00AA_A000);
    run_walk("R9 R13 high reserved", la9, 2'b01, 1, 0, 0, 0);
    map(la10, 0, F_ALL, 64'h5, F_ALL, F_ALL, 64'h0000_0000_00BB_B000);
    run_walk("R6 combined and", la10, 2'b00, 0, 1, 0, 1);
    run_walk("R7 R13 write to read-only", la10, 2'b01, 1, 0, 0, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule